// File: doc/BRIEF.md
# Timer Count-Source Selector

This block sits in front of a general-purpose timer counter and decides what makes the counter advance. In internal mode the counter advances on every cycle of the block clock while counting is enabled. In the two external modes it advances once for each qualifying edge on an input that software has picked. That input is one of four trigger lines from neighbouring timers, two capture-channel pins or an external trigger pin.

Two configuration fields choose the source. A 3-bit slave-mode code selects internal counting (000) or edge counting on the trigger input (111). A 3-bit trigger-select code picks the trigger input. A separate enable bit routes rising edges of the external trigger pin straight to the counter. All pins pass through a two-flop synchronizer. The two channel pins and the external trigger pin then pass through a programmable glitch filter, and channel 2 has a polarity control, before edge detection. The counter is 16 bits wide, counts up and returns to zero when it wraps or when an update is forced.

Top module: `tmr_src_sel`

## Requirements
- R1: After reset, `cnt` is 0 and `psc_ce` is 0.
- R2: With `slave_mode` = 000 and `ext_clk_en` = 0, `psc_ce` equals `cnt_en` every cycle and `cnt` rises by one after each enabled cycle.
- R3: While `cnt_en` is 0, `psc_ce` stays 0 and `cnt` holds its value in every mode, whatever the inputs do.
- R4: A one-cycle `upd_gen` pulse makes `cnt` equal 0 one cycle later. This takes priority over a count in the same cycle.
- R5: The counter wraps from 16'hFFFF to 0 on the next count.
- R6: With `slave_mode` = 111, `cnt` advances once per rising edge of the input chosen by `trig_sel`. Code 101 selects filtered `ch1_in`, 110 selects filtered `ch2_in` after polarity, and 111 selects filtered `etr_in`. Edges on inputs that are not selected are ignored.
- R7: With `slave_mode` = 111 and `trig_sel` = 0xx, the input is `itr_in[trig_sel[1:0]]`, counted on its rising edges. The other three lines are ignored.
- R8: With `slave_mode` = 111 and `trig_sel` = 100, both rising and falling edges of filtered `ch1_in` are counted.
- R9: With `ch2_pol` = 0, rising edges of filtered `ch2_in` are counted. With `ch2_pol` = 1, falling edges are counted.
- R10: Each filtered input changes only after N consecutive synchronized samples that differ from it. N is 1 when the input's 4-bit filter field is 0 and equals the field value otherwise. Shorter pulses are not counted.
- R11: With `ext_clk_en` = 1 and `slave_mode` not 111, `cnt` advances once per rising edge of filtered `etr_in`. With `slave_mode` = 111, edge counting on the trigger input takes precedence.
- R12: With `ext_clk_en` = 0 and `slave_mode` neither 000 nor 111, the counter does not advance.
- R13: Each counted edge produces exactly one single-cycle `psc_ce` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable |
| upd_gen | input | 1 | One-cycle forced update; reloads the counter to 0 |
| slave_mode | input | 3 | 000 internal, 111 trigger edge counting, others idle |
| trig_sel | input | 3 | 0xx internal trigger n, 100 ch1 both edges, 101 ch1, 110 ch2, 111 ext trigger |
| ext_clk_en | input | 1 | Count rising edges of the filtered external trigger |
| ch2_pol | input | 1 | Channel 2 edge polarity: 0 rising, 1 falling |
| ch1_flt | input | 4 | Channel 1 filter length |
| ch2_flt | input | 4 | Channel 2 filter length |
| etr_flt | input | 4 | External trigger filter length |
| ch1_in | input | 1 | Capture channel 1 pin, asynchronous |
| ch2_in | input | 1 | Capture channel 2 pin, asynchronous |
| etr_in | input | 1 | External trigger pin, asynchronous |
| itr_in | input | 4 | Trigger lines from other timers |
| psc_ce | output | 1 | Prescaler clock enable (counter advance strobe) |
| cnt | output | 16 | Counter value |

## Verification
The assertions assume that `upd_gen` arrives as a single-cycle pulse. They also assume that the mode, select and polarity fields change only while `cnt_en` is 0, because a polarity flip on a held level looks like an edge. The stimulus follows both rules: it drops the enable, waits several cycles, reprograms the fields and only then raises the enable again. Every pin pulse it drives lasts at least as many cycles as the filter length under test, unless the test is checking that a short pulse is rejected. Each burst ends with a quiet period longer than the synchronizer and filter latency before the expected count is queued.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam logic [2:0] SM_INTERNAL = 3'b000;
    localparam logic [2:0] SM_EXTCLK   = 3'b111;

    localparam logic [2:0] TS_CH1_BOTH = 3'b100;
    localparam logic [2:0] TS_CH1      = 3'b101;
    localparam logic [2:0] TS_CH2      = 3'b110;
    localparam logic [2:0] TS_ETR      = 3'b111;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CLK,
        SRC_TRIG,
        SRC_ETR
    } src_e;

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/tcs_filter.sv
module tcs_filter #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] len,
    output logic             dout
);
    typedef struct packed {
        logic             lvl;
        logic [FLT_W-1:0] run;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic [FLT_W:0] need;
    logic [FLT_W:0] run_inc;

    always_comb begin
        st_d    = st_q;
        need    = (len == '0) ? {{FLT_W{1'b0}}, 1'b1} : {1'b0, len};
        run_inc = {1'b0, st_q.run} + 1'b1;
        if (din == st_q.lvl) begin
            st_d.run = '0;
        end else if (run_inc >= need) begin
            st_d.lvl = din;
            st_d.run = '0;
        end else begin
            st_d.run = run_inc[FLT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;

    // R10
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(din) == st_q.lvl));

    // R10
    filt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((len == 4'd1) && (din != st_q.lvl)) |=> (st_q.lvl == $past(din)));
endmodule

// File: rtl/tcs_trig.sv
module tcs_trig
    import tcs_pkg::*;
#(
    parameter int ITR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [2:0]       slave_mode,
    input  logic [2:0]       trig_sel,
    input  logic             ext_clk_en,
    input  logic             ch2_pol,
    input  logic             ti1f,
    input  logic             ti2f,
    input  logic             etrf,
    input  logic [ITR_N-1:0] itr_s,
    output logic             psc_ce
);
    localparam int CAND_N    = ITR_N + 3;
    localparam int IDX_CH1   = ITR_N;
    localparam int IDX_CH2   = ITR_N + 1;
    localparam int IDX_ETR   = ITR_N + 2;
    localparam int ITR_SEL_W = (ITR_N > 1) ? $clog2(ITR_N) : 1;

    typedef struct packed {
        logic [CAND_N-1:0] prev;
    } trg_st_t;

    trg_st_t           st_d, st_q;
    logic [CAND_N-1:0] cand, rise, fall;
    logic [ITR_N-1:0]  itr_rise;
    logic              trig_edge;
    src_e              src;

    always_comb begin
        cand      = {etrf, ti2f ^ ch2_pol, ti1f, itr_s};
        rise      = cand & ~st_q.prev;
        fall      = ~cand & st_q.prev;
        itr_rise  = rise[ITR_N-1:0];
        st_d.prev = cand;

        case (trig_sel)
            TS_CH1_BOTH: trig_edge = rise[IDX_CH1] | fall[IDX_CH1];
            TS_CH1:      trig_edge = rise[IDX_CH1];
            TS_CH2:      trig_edge = rise[IDX_CH2];
            TS_ETR:      trig_edge = rise[IDX_ETR];
            default:     trig_edge = itr_rise[trig_sel[ITR_SEL_W-1:0]];
        endcase

        if (slave_mode == SM_EXTCLK)       src = SRC_TRIG;
        else if (ext_clk_en)               src = SRC_ETR;
        else if (slave_mode == SM_INTERNAL) src = SRC_CLK;
        else                               src = SRC_NONE;

        case (src)
            SRC_CLK:  psc_ce = cnt_en;
            SRC_TRIG: psc_ce = cnt_en & trig_edge;
            SRC_ETR:  psc_ce = cnt_en & rise[IDX_ETR];
            default:  psc_ce = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    ce_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_ce |-> cnt_en);

    // R12
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slave_mode != SM_INTERNAL) && (slave_mode != SM_EXTCLK) && !ext_clk_en)
        |-> !psc_ce);

    // R13
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload)    st_d.val = '0;
        else if (tick) st_d.val = st_q.val + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.val;

    // R4
    upd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.val == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload) |=> (st_q.val == $past(st_q.val) + 1'b1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(st_q.val));
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tcs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ITR_N       = 4,
    parameter int FLT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             upd_gen,
    input  logic [2:0]       slave_mode,
    input  logic [2:0]       trig_sel,
    input  logic             ext_clk_en,
    input  logic             ch2_pol,
    input  logic [FLT_W-1:0] ch1_flt,
    input  logic [FLT_W-1:0] ch2_flt,
    input  logic [FLT_W-1:0] etr_flt,
    input  logic             ch1_in,
    input  logic             ch2_in,
    input  logic             etr_in,
    input  logic [ITR_N-1:0] itr_in,
    output logic             psc_ce,
    output logic [CNT_W-1:0] cnt
);
    localparam int PIN_N  = 3;
    localparam int SYNC_W = PIN_N + ITR_N;

    logic [SYNC_W-1:0]            raw_s;
    logic [PIN_N-1:0]             pin_s, pin_f;
    logic [PIN_N-1:0][FLT_W-1:0]  flt_len;
    logic [ITR_N-1:0]             itr_s;

    tcs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({etr_in, ch2_in, ch1_in, itr_in}),
        .dout (raw_s)
    );

    assign itr_s   = raw_s[ITR_N-1:0];
    assign pin_s   = raw_s[SYNC_W-1:ITR_N];
    assign flt_len = {etr_flt, ch2_flt, ch1_flt};

    for (genvar g = 0; g < PIN_N; g++) begin : g_flt
        tcs_filter #(.FLT_W(FLT_W)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_s[g]),
            .len  (flt_len[g]),
            .dout (pin_f[g])
        );
    end

    tcs_trig #(.ITR_N(ITR_N)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .slave_mode(slave_mode),
        .trig_sel  (trig_sel),
        .ext_clk_en(ext_clk_en),
        .ch2_pol   (ch2_pol),
        .ti1f      (pin_f[0]),
        .ti2f      (pin_f[1]),
        .etrf      (pin_f[2]),
        .itr_s     (itr_s),
        .psc_ce    (psc_ce)
    );

    tcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (psc_ce),
        .reload(upd_gen),
        .cnt   (cnt)
    );
endmodule

// File: tb/sim_tmr_src_sel.sv
`timescale 1ns/1ps
module sim_tmr_src_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 0, upd_gen = 0, ext_clk_en = 0, ch2_pol = 0;
    logic [2:0]  slave_mode = 3'b000, trig_sel = 3'b000;
    logic [3:0]  ch1_flt = 0, ch2_flt = 0, etr_flt = 0;
    logic        ch1_in = 0, ch2_in = 0, etr_in = 0;
    logic [3:0]  itr_in = 0;
    logic        psc_ce;
    logic [15:0] cnt;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] exp_cnt = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    tmr_src_sel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .upd_gen(upd_gen),
        .slave_mode(slave_mode), .trig_sel(trig_sel), .ext_clk_en(ext_clk_en),
        .ch2_pol(ch2_pol), .ch1_flt(ch1_flt), .ch2_flt(ch2_flt), .etr_flt(etr_flt),
        .ch1_in(ch1_in), .ch2_in(ch2_in), .etr_in(etr_in), .itr_in(itr_in),
        .psc_ce(psc_ce), .cnt(cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side: queue the expected counter value, called right after a negedge
    task automatic expect_cnt(input string tag);
        exp_t e;
        e.val = exp_cnt;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares queued expectations with the counter between edges
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(cnt == e.val, e.tag, int'(cnt), int'(e.val));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which, input int hi, input int lo);
        case (which)
            0: ch1_in = 1'b1;
            1: ch2_in = 1'b1;
            2: etr_in = 1'b1;
            default: itr_in[which-3] = 1'b1;
        endcase
        idle(hi);
        case (which)
            0: ch1_in = 1'b0;
            1: ch2_in = 1'b0;
            2: etr_in = 1'b0;
            default: itr_in[which-3] = 1'b0;
        endcase
        idle(lo);
    endtask

    task automatic setup(input logic [2:0] sm, input logic [2:0] ts, input logic ece, input logic pol);
        cnt_en = 1'b0;
        idle(4);
        slave_mode = sm;
        trig_sel   = ts;
        ext_clk_en = ece;
        ch2_pol    = pol;
        idle(6);
        cnt_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ce_cycles;
        idle(3);
        // R1 reset state
        check(cnt == 16'd0, "R1 cnt", int'(cnt), 0);
        check(psc_ce == 1'b0, "R1 psc_ce", int'(psc_ce), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 internal clock counting
        cnt_en = 1'b1;
        @(negedge clk);
        check(psc_ce == 1'b1, "R2 psc_ce", int'(psc_ce), 1);
        idle(9);
        cnt_en = 1'b0;
        exp_cnt = 16'd10;
        expect_cnt("R2 internal count");

        // R3 hold while disabled
        idle(5);
        expect_cnt("R3 hold internal");

        // R4 forced update beats a same-cycle count
        cnt_en = 1'b1; upd_gen = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0; upd_gen = 1'b0;
        exp_cnt = 16'd0;
        expect_cnt("R4 reload");

        // R6 / R9 channel 2 rising edges
        setup(3'b111, 3'b110, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1, 4, 4);
        idle(8);
        exp_cnt += 3;
        expect_cnt("R6 ch2 rising");

        // R3 disabled in edge mode: pulses ignored
        cnt_en = 1'b0;
        idle(2);
        pulse(1, 4, 10);
        expect_cnt("R3 hold edge mode");

        // R9 falling polarity
        setup(3'b111, 3'b110, 1'b0, 1'b1);
        ch2_in = 1'b1;
        idle(10);
        expect_cnt("R9 no count on rise");
        ch2_in = 1'b0;
        idle(10);
        exp_cnt += 1;
        expect_cnt("R9 count on fall");

        // R6 channel 1 rising, channel 2 ignored
        setup(3'b111, 3'b101, 1'b0, 1'b0);
        pulse(0, 4, 4);
        pulse(0, 4, 4);
        pulse(1, 4, 8);
        exp_cnt += 2;
        expect_cnt("R6 ch1 select");

        // R6 external trigger via trigger select
        setup(3'b111, 3'b111, 1'b0, 1'b0);
        pulse(2, 3, 3);
        pulse(2, 3, 8);
        pulse(0, 4, 8);
        exp_cnt += 2;
        expect_cnt("R6 etr select");

        // R8 both edges of channel 1
        setup(3'b111, 3'b100, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(0, 4, 4);
        idle(6);
        exp_cnt += 6;
        expect_cnt("R8 both edges");

        // R7 internal trigger 2 selected, line 1 ignored
        setup(3'b111, 3'b010, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) pulse(5, 3, 3);
        pulse(4, 3, 3);
        pulse(4, 3, 8);
        exp_cnt += 4;
        expect_cnt("R7 itr select");

        // R10 filter length 4: 3-cycle pulse rejected, 4-cycle accepted
        setup(3'b111, 3'b110, 1'b0, 1'b0);
        cnt_en = 1'b0;
        ch2_flt = 4'd4;
        idle(4);
        cnt_en = 1'b1;
        pulse(1, 3, 12);
        expect_cnt("R10 short pulse rejected");
        pulse(1, 4, 12);
        exp_cnt += 1;
        expect_cnt("R10 full pulse accepted");
        cnt_en = 1'b0;
        ch2_flt = 4'd0;

        // R11 external clock mode 2
        setup(3'b000, 3'b000, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) pulse(2, 3, 3);
        idle(8);
        exp_cnt += 3;
        expect_cnt("R11 ext clock count");
        idle(5);
        expect_cnt("R11 no free running");

        // R11 precedence of trigger edge counting
        setup(3'b111, 3'b110, 1'b1, 1'b0);
        pulse(2, 3, 3);
        pulse(2, 3, 8);
        expect_cnt("R11 precedence");

        // R12 unsupported slave-mode code
        setup(3'b011, 3'b110, 1'b0, 1'b0);
        idle(10);
        pulse(1, 4, 8);
        expect_cnt("R12 idle mode");

        // R13 one strobe per edge
        setup(3'b111, 3'b110, 1'b0, 1'b0);
        ce_cycles = 0;
        ch2_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (psc_ce) ce_cycles++;
        end
        ch2_in = 1'b0;
        check(ce_cycles == 1, "R13 single strobe", ce_cycles, 1);
        idle(8);
        exp_cnt += 1;
        expect_cnt("R13 count after strobe");

        // R5 wrap
        setup(3'b000, 3'b000, 1'b0, 1'b0);
        cnt_en = 1'b0;
        upd_gen = 1'b1;
        @(negedge clk);
        upd_gen = 1'b0;
        cnt_en = 1'b1;
        idle(65535);
        cnt_en = 1'b0;
        exp_cnt = 16'hFFFF;
        expect_cnt("R5 top value");
        @(negedge clk);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        exp_cnt = 16'h0000;
        expect_cnt("R5 wrap to zero");

        idle(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule